// File: doc/BRIEF.md
# Configuration Stream Header Classifier

This block sits beside a 32-bit configuration word stream on its way to a passive-parallel configuration port and watches it without touching it. A start pulse arms it for a new stream. From the first two words it identifies what kind of image is being sent: whether it is plain or encrypted, and whether it is the peripheral or the core part of the image. It does this by looking for 16-bit identifier values among the first four halfwords.

Two header words at fixed positions carry flags that the block decodes. Word 69 holds the encryption field and word 229 holds the compression bit. Once word 229 has been accepted, the block combines these flags with the configuration width and publishes the clock-to-data ratio code that the configuration port must use. A stream that ends before it reaches word 229 is flagged as too short and yields no ratio.

The four identifier values are parameters. Word positions count from 0. Halfword 0 is bits [15:0] of word 0, halfword 1 is bits [31:16] of word 0, and halfwords 2 and 3 are the two halves of word 1 in the same way.

Top module: `hdr_classifier`

## Requirements
- R1: After reset, and in the cycle after a start pulse, done, len_err and ratio_valid are 0, ratio_code, encrypted and compressed are 0, sec_type is 0 (invalid) and sect_type is 0 (unknown).
- R2: sec_type reports 1 for the plain identifier and 2 for the encrypted identifier. Candidate positions are tried in this order: halfword 0, halfword 1, then halfword 1, halfword 2. At each candidate position the plain identifier wins over the encrypted one. The first hit decides. If nothing matches, sec_type is 0. The result appears the cycle after word 1 is accepted.
- R3: When the security hit came from the scan step with base i (i = 0 or 1), the section is looked up in halfword i+1 and then in halfword i+2. It reports 1 for the peripheral identifier and 2 for the core identifier, with peripheral winning at each position. If neither matches, sect_type is 0 (unknown). sect_type is also 0 whenever sec_type is 0.
- R4: encrypted is 1 exactly when bits [3:2] of word 69 are not both zero.
- R5: compressed is 1 exactly when bit 1 of word 229 is 0.
- R6: With cfg_wide = 0 (16-bit port), ratio_code is 0 (x1) when the stream is neither encrypted nor compressed. It is 2 (x4) when the stream is compressed, and 1 (x2) when it is encrypted only. With cfg_wide = 1, an uncompressed, unencrypted stream also gives 0.
- R7: With cfg_wide = 1 (32-bit port), every ratio other than x1 moves up one code: a compressed stream gives 3 (x8) and an encrypted-only stream gives 2 (x4).
- R8: done is a one-cycle pulse in the cycle after word 229 is accepted. ratio_valid rises in the same cycle, and ratio_code is valid from then on.
- R9: If word_last arrives with a word whose index is below 229, len_err goes to 1 and stays there. done never pulses and ratio_valid stays 0.
- R10: Once a stream has finished, whether by done or by len_err, further words are ignored and all outputs hold until the next start. Words sent after reset but before any start are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms the block for a new stream and clears all results |
| word_valid | input | 1 | A configuration word is present this cycle |
| word_data | input | 32 | Configuration word |
| word_last | input | 1 | This word is the final one of the stream |
| cfg_wide | input | 1 | 1 selects a 32-bit configuration port, 0 a 16-bit port; sampled with word 229 |
| done | output | 1 | One-cycle pulse once the ratio is known |
| len_err | output | 1 | Stream ended before word 229 |
| ratio_valid | output | 1 | ratio_code holds a result |
| ratio_code | output | 2 | Clock-to-data ratio: 0 x1, 1 x2, 2 x4, 3 x8 |
| encrypted | output | 1 | Encryption field of word 69 is non-zero |
| compressed | output | 1 | Compression bit of word 229 is clear |
| sec_type | output | 2 | 0 invalid, 1 plain, 2 encrypted |
| sect_type | output | 2 | 0 unknown, 1 peripheral, 2 core |

## Verification
A word counter that drifts by one would read the flags from the wrong words. The stream table places distinct values around words 69 and 229, so such a slip shows up as a wrong encrypted, compressed or ratio_code value. It also moves the done pulse off the cycle that follows word 229, and the bench times that pulse exactly even when valid has gaps. A wrong priority in the identifier scan shows up in sec_type or sect_type one cycle after word 1. The table includes vectors where a later position would give a different answer. A phase register that fails to close would let the words sent after completion, or before any start, change the outputs or raise a second done.

// File: rtl/hdrcls_pkg.sv
// Shared types for the configuration stream header classifier.
// Assumes nothing beyond IEEE 1800-2017 enum and struct support.
package hdrcls_pkg;

    typedef enum logic [1:0] {
        SEC_INVALID = 2'd0,
        SEC_PLAIN   = 2'd1,
        SEC_CIPHER  = 2'd2
    } sec_e;

    typedef enum logic [1:0] {
        SECT_UNKNOWN = 2'd0,
        SECT_PERIPH  = 2'd1,
        SECT_CORE    = 2'd2
    } sect_e;

    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_END  = 2'd2
    } phase_e;

    // Identifier hits of one halfword.
    typedef struct packed {
        logic core;
        logic periph;
        logic cipher;
        logic plain;
    } hw_hits_t;

endpackage

// File: rtl/hdrcls_word_track.sv
// Word position tracker.
// Counts accepted words of the stream armed by start. It flags the word at
// LAST_IDX and a word_last that arrives earlier. Assumes LAST_IDX fits in CNT_W.
module hdrcls_word_track
    import hdrcls_pkg::*;
#(
    parameter int LAST_IDX = 229,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_valid,
    input  logic             word_last,
    output logic             accept,
    output logic [CNT_W-1:0] idx,
    output logic             hit_final,
    output logic             short_end
);

    phase_e phase_q;
    logic   at_final;

    // Acceptance and end-of-header detection.
    always_comb begin
        accept    = (phase_q == PH_RUN) && word_valid && !start;
        at_final  = (idx == CNT_W'(LAST_IDX));
        hit_final = accept && at_final;
        short_end = accept && word_last && !at_final;
    end

    // Phase and word index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx     <= '0;
        end else if (start) begin
            phase_q <= PH_RUN;
            idx     <= '0;
        end else if (accept) begin
            if (at_final || word_last) begin
                phase_q <= PH_END;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdrcls_id_cmp.sv
// Identifier comparator.
// Compares every halfword of one word against the four identifier values.
// Assumes WORD_W is a whole multiple of HW_W.
module hdrcls_id_cmp
    import hdrcls_pkg::*;
#(
    parameter int              WORD_W    = 32,
    parameter int              HW_W      = 16,
    parameter logic [HW_W-1:0] ID_PLAIN  = 16'h6A8D,
    parameter logic [HW_W-1:0] ID_CIPHER = 16'h6A65,
    parameter logic [HW_W-1:0] ID_PERIPH = 16'h3C51,
    parameter logic [HW_W-1:0] ID_CORE   = 16'h3C52,
    localparam int             N_HW      = WORD_W / HW_W
) (
    input  logic [WORD_W-1:0]        word,
    output hw_hits_t [N_HW-1:0]      hits
);

    for (genvar g = 0; g < N_HW; g++) begin : g_hw
        logic [HW_W-1:0] hw;
        // Slice one halfword and compare it.
        always_comb begin
            hw               = word[g*HW_W +: HW_W];
            hits[g].plain    = (hw == ID_PLAIN);
            hits[g].cipher   = (hw == ID_CIPHER);
            hits[g].periph   = (hw == ID_PERIPH);
            hits[g].core     = (hw == ID_CORE);
        end
    end

endmodule

// File: rtl/hdrcls_resolve.sv
// Identifier priority resolver.
// Walks scan bases 0..SCAN_POS-1. For each base it tries the base halfword
// and then the next one for a security identifier, plain before encrypted.
// The first hit fixes the security type, and the section is then searched
// one and two halfwords above that base. Assumes hits covers SCAN_POS+2
// halfwords.
module hdrcls_resolve
    import hdrcls_pkg::*;
#(
    parameter int  SCAN_POS = 2,
    localparam int N_HW     = SCAN_POS + 2
) (
    input  hw_hits_t [N_HW-1:0] hits,
    output sec_e                sec,
    output sect_e               sect
);

    logic found;

    // Priority walk over scan bases.
    always_comb begin
        sec   = SEC_INVALID;
        sect  = SECT_UNKNOWN;
        found = 1'b0;
        for (int i = 0; i < SCAN_POS; i++) begin
            if (!found) begin
                if (hits[i].plain) begin
                    sec = SEC_PLAIN;  found = 1'b1;
                end else if (hits[i].cipher) begin
                    sec = SEC_CIPHER; found = 1'b1;
                end else if (hits[i+1].plain) begin
                    sec = SEC_PLAIN;  found = 1'b1;
                end else if (hits[i+1].cipher) begin
                    sec = SEC_CIPHER; found = 1'b1;
                end
                if (found) begin
                    if (hits[i+1].periph)      sect = SECT_PERIPH;
                    else if (hits[i+1].core)   sect = SECT_CORE;
                    else if (hits[i+2].periph) sect = SECT_PERIPH;
                    else if (hits[i+2].core)   sect = SECT_CORE;
                    else                       sect = SECT_UNKNOWN;
                end
            end
        end
    end

endmodule

// File: rtl/hdrcls_ratio_sel.sv
// Clock-to-data ratio selector.
// Maps the encryption and compression flags and the port width to a ratio
// code. A wide port moves every ratio above x1 up one code.
module hdrcls_ratio_sel
    import hdrcls_pkg::*;
(
    input  logic   enc,
    input  logic   cmp,
    input  logic   wide,
    output ratio_e ratio
);

    logic [1:0] base;

    // Table lookup of the ratio code.
    always_comb begin
        base = cmp ? 2'(RATIO_X4) : 2'(RATIO_X2);
        if (!enc && !cmp) begin
            ratio = RATIO_X1;
        end else begin
            ratio = ratio_e'(base + {1'b0, wide});
        end
    end

endmodule

// File: rtl/hdr_classifier.sv
// Configuration stream header classifier (top).
// Observes a word stream after a start pulse. It records identifier hits of
// word 0 and resolves the image type when word 1 arrives. It takes the
// encryption field from word ENC_IDX and the compression bit from word
// CMP_IDX, and publishes the ratio one cycle after word CMP_IDX. Assumes
// the header identifiers span the first two words (four 16-bit halfwords)
// and that ENC_IDX lies below CMP_IDX.
module hdr_classifier
    import hdrcls_pkg::*;
#(
    parameter int        ENC_IDX   = 69,
    parameter int        CMP_IDX   = 229,
    parameter int        ENC_LSB   = 2,
    parameter int        ENC_MSB   = 3,
    parameter int        CMP_BIT   = 1,
    parameter logic [15:0] ID_PLAIN  = 16'h6A8D,
    parameter logic [15:0] ID_CIPHER = 16'h6A65,
    parameter logic [15:0] ID_PERIPH = 16'h3C51,
    parameter logic [15:0] ID_CORE   = 16'h3C52
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic        word_last,
    input  logic        cfg_wide,
    output logic        done,
    output logic        len_err,
    output logic        ratio_valid,
    output logic [1:0]  ratio_code,
    output logic        encrypted,
    output logic        compressed,
    output logic [1:0]  sec_type,
    output logic [1:0]  sect_type
);

    localparam int WORD_W      = 32;
    localparam int HW_W        = 16;
    localparam int HW_PER_WORD = WORD_W / HW_W;
    localparam int SCAN_POS    = 2;
    localparam int HDR_HW      = SCAN_POS + 2;
    localparam int MIN_WORDS   = CMP_IDX + 1;
    localparam int CNT_W       = $clog2(MIN_WORDS + 1);

    logic                        accept;
    logic [CNT_W-1:0]            idx;
    logic                        hit_final;
    logic                        short_end;
    hw_hits_t [HW_PER_WORD-1:0]  hits_now;
    hw_hits_t [HW_PER_WORD-1:0]  hits_w0_q;
    hw_hits_t [HDR_HW-1:0]       hits_all;
    sec_e                        sec_res;
    sect_e                       sect_res;
    ratio_e                      ratio_res;
    logic                        cmp_now;
    logic                        clr;

    sec_e   sec_q;
    sect_e  sect_q;
    ratio_e ratio_q;
    logic   enc_q, cmp_q, done_q, valid_q, err_q;

    hdrcls_word_track #(
        .LAST_IDX (CMP_IDX),
        .CNT_W    (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_valid (word_valid),
        .word_last  (word_last),
        .accept     (accept),
        .idx        (idx),
        .hit_final  (hit_final),
        .short_end  (short_end)
    );

    hdrcls_id_cmp #(
        .WORD_W    (WORD_W),
        .HW_W      (HW_W),
        .ID_PLAIN  (ID_PLAIN),
        .ID_CIPHER (ID_CIPHER),
        .ID_PERIPH (ID_PERIPH),
        .ID_CORE   (ID_CORE)
    ) u_cmp (
        .word (word_data),
        .hits (hits_now)
    );

    // Word 0 hits held below the live word 1 hits.
    assign hits_all = {hits_now, hits_w0_q};

    hdrcls_resolve #(
        .SCAN_POS (SCAN_POS)
    ) u_resolve (
        .hits (hits_all),
        .sec  (sec_res),
        .sect (sect_res)
    );

    // Compression bit has inverted polarity.
    assign cmp_now = ~word_data[CMP_BIT];

    hdrcls_ratio_sel u_ratio (
        .enc   (enc_q),
        .cmp   (cmp_now),
        .wide  (cfg_wide),
        .ratio (ratio_res)
    );

    assign clr = !rst_n || start;

    // Header hit capture and type resolution.
    always_ff @(posedge clk) begin
        if (clr) begin
            hits_w0_q <= '0;
            sec_q     <= SEC_INVALID;
            sect_q    <= SECT_UNKNOWN;
        end else if (accept) begin
            if (idx == CNT_W'(0)) begin
                hits_w0_q <= hits_now;
            end
            if (idx == CNT_W'(1)) begin
                sec_q  <= sec_res;
                sect_q <= sect_res;
            end
        end
    end

    // Flag capture, ratio publication and end-of-stream status.
    always_ff @(posedge clk) begin
        if (clr) begin
            enc_q   <= 1'b0;
            cmp_q   <= 1'b0;
            ratio_q <= RATIO_X1;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= hit_final;
            if (accept && idx == CNT_W'(ENC_IDX)) begin
                enc_q <= |word_data[ENC_MSB:ENC_LSB];
            end
            if (hit_final) begin
                cmp_q   <= cmp_now;
                ratio_q <= ratio_res;
                valid_q <= 1'b1;
            end
            if (short_end) begin
                err_q <= 1'b1;
            end
        end
    end

    assign done        = done_q;
    assign len_err     = err_q;
    assign ratio_valid = valid_q;
    assign ratio_code  = ratio_q;
    assign encrypted   = enc_q;
    assign compressed  = cmp_q;
    assign sec_type    = sec_q;
    assign sect_type   = sect_q;

endmodule

// File: rtl/hdrcls_checker.sv
// Port-level property checker for hdr_classifier, attached by bind.
module hdrcls_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic       len_err,
    input logic       ratio_valid,
    input logic [1:0] ratio_code,
    input logic       encrypted,
    input logic       compressed,
    input logic [1:0] sec_type,
    input logic [1:0] sect_type
);

    // R1: a start pulse clears every result.
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ratio_valid && !len_err && !done && sec_type == 2'd0 && sect_type == 2'd0));

    // R2: the security code never takes the unused value.
    p_sec_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_type != 2'd3);

    // R3: no section is reported without a security hit.
    p_sect_needs_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_type == 2'd0) |-> (sect_type == 2'd0));

    // R6: plain, uncompressed streams run at x1.
    p_x1_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_valid && !encrypted && !compressed) |-> (ratio_code == 2'd0));

    // R7: compressed streams use x4 or x8.
    p_cmp_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_valid && compressed) |-> (ratio_code >= 2'd2));

    // R8: done lasts one cycle and comes with a valid ratio.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ratio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ratio_valid && !len_err));

    // R9: a short stream never yields a ratio.
    p_err_no_ratio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!ratio_valid && !done));

    // R10: results hold until the next start.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_valid && !start) |=> (ratio_valid && $stable(ratio_code) &&
                                     $stable(sec_type) && $stable(sect_type)));
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !start) |=> len_err);

endmodule

bind hdr_classifier hdrcls_checker u_hdrcls_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .len_err     (len_err),
    .ratio_valid (ratio_valid),
    .ratio_code  (ratio_code),
    .encrypted   (encrypted),
    .compressed  (compressed),
    .sec_type    (sec_type),
    .sect_type   (sect_type)
);

// File: tb/hdr_classifier_bench.sv
module hdr_classifier_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam logic [15:0] P = 16'h6A8D;
    localparam logic [15:0] C = 16'h6A65;
    localparam logic [15:0] F = 16'h3C51;
    localparam logic [15:0] K = 16'h3C52;
    localparam logic [15:0] X = 16'h0000;

    typedef struct packed {
        logic [15:0] h0, h1, h2, h3;
        logic [3:0]  w69;
        logic [3:0]  w229;
        logic [8:0]  nwords;
        logic        wide;
        logic        gap;
        logic [1:0]  e_sec;
        logic [1:0]  e_sect;
        logic        e_enc;
        logic        e_cmp;
        logic [1:0]  e_ratio;
        logic        e_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{P, F, X, X, 4'h0, 4'h2, 9'd230, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0},
        '{X, C, K, X, 4'h4, 4'h0, 9'd230, 1'b0, 1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0},
        '{X, X, C, F, 4'h8, 4'h2, 9'd230, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 2'd2, 1'b0},
        '{P, X, X, X, 4'h0, 4'h0, 9'd230, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0},
        '{X, X, X, X, 4'hC, 4'h2, 9'd230, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0},
        '{X, P, X, K, 4'h0, 4'h2, 9'd230, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},
        '{C, K, F, X, 4'h4, 4'h0, 9'd230, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 2'd3, 1'b0},
        '{P, F, X, X, 4'h4, 4'h0, 9'd229, 1'b0, 1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1},
        '{P, F, X, X, 4'h0, 4'h0, 9'd1,   1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1},
        '{C, P, F, X, 4'h0, 4'h2, 9'd230, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0},
        '{X, X, C, F, 4'h4, 4'h0, 9'd230, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1, 1'b1, 2'd2, 1'b0},
        '{P, K, X, X, 4'h0, 4'h0, 9'd240, 1'b0, 1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 2'd2, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        done, len_err, ratio_valid, encrypted, compressed;
    logic [1:0]  ratio_code, sec_type, sect_type;

    int checks = 0;
    int errors = 0;
    int done_hits;
    int done_idx;
    int last_idx;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_classifier u_hdr_classifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_last   (word_last),
        .cfg_wide    (cfg_wide),
        .done        (done),
        .len_err     (len_err),
        .ratio_valid (ratio_valid),
        .ratio_code  (ratio_code),
        .encrypted   (encrypted),
        .compressed  (compressed),
        .sec_type    (sec_type),
        .sect_type   (sect_type)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input vec_t v, input int k);
        logic [31:0] w;
        w = {k[7:0], 8'h5A, k[7:0], 8'hC3};
        if (k == 0)   w = {v.h1, v.h0};
        if (k == 1)   w = {v.h3, v.h2};
        if (k == 69)  w = {w[31:4], v.w69};
        if (k == 229) w = {w[31:4], v.w229};
        return w;
    endfunction

    task automatic sample_done();
        if (done) begin
            done_hits++;
            done_idx = last_idx;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Feeds one stream; done timing is recorded against accepted word index.
    task automatic feed(input vec_t v);
        done_hits = 0;
        done_idx  = -1;
        last_idx  = -1;
        cfg_wide  = v.wide;
        for (int k = 0; k < int'(v.nwords); k++) begin
            if (v.gap && (k % 5 == 3)) begin
                @(negedge clk);
                sample_done();
                word_valid = 1'b0;
                word_last  = 1'b0;
            end
            @(negedge clk);
            sample_done();
            word_valid = 1'b1;
            word_data  = word_at(v, k);
            word_last  = (k == int'(v.nwords) - 1);
            last_idx   = k;
        end
        @(negedge clk);
        sample_done();
        word_valid = 1'b0;
        word_last  = 1'b0;
        @(negedge clk);
        sample_done();
    endtask

    task automatic check_vec(input vec_t v, input int n);
        string rr;
        rr = v.wide ? "R7" : "R6";
        check("R2", $sformatf("vec%0d sec_type", n), sec_type, v.e_sec);
        check("R3", $sformatf("vec%0d sect_type", n), sect_type, v.e_sect);
        check("R4", $sformatf("vec%0d encrypted", n), encrypted, v.e_enc);
        check("R9", $sformatf("vec%0d len_err", n), len_err, v.e_err);
        check("R8", $sformatf("vec%0d ratio_valid", n), ratio_valid, !v.e_err);
        if (!v.e_err) begin
            check("R5", $sformatf("vec%0d compressed", n), compressed, v.e_cmp);
            check(rr, $sformatf("vec%0d ratio_code", n), ratio_code, v.e_ratio);
            check("R8", $sformatf("vec%0d done count", n), done_hits, 1);
            check("R8", $sformatf("vec%0d done after word", n), done_idx, 229);
        end else begin
            check("R9", $sformatf("vec%0d done count", n), done_hits, 0);
        end
    endtask

    task automatic check_cleared(input string tag);
        check("R1", {tag, " done"}, done, 0);
        check("R1", {tag, " len_err"}, len_err, 0);
        check("R1", {tag, " ratio_valid"}, ratio_valid, 0);
        check("R1", {tag, " ratio_code"}, ratio_code, 0);
        check("R1", {tag, " encrypted"}, encrypted, 0);
        check("R1", {tag, " compressed"}, compressed, 0);
        check("R1", {tag, " sec_type"}, sec_type, 0);
        check("R1", {tag, " sect_type"}, sect_type, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cleared("reset");

        // R10: words before any start are ignored.
        feed(VECS[1]);
        check("R10", "pre-start done count", done_hits, 0);
        check("R10", "pre-start ratio_valid", ratio_valid, 0);
        check("R10", "pre-start sec_type", sec_type, 0);
        check("R10", "pre-start encrypted", encrypted, 0);

        // Table walk.
        for (int n = 0; n < NV; n++) begin
            pulse_start();
            feed(VECS[n]);
            check_vec(VECS[n], n);
        end

        // R10: after completion a new stream without start changes nothing.
        feed(VECS[4]);
        check("R10", "post-done done count", done_hits, 0);
        check("R10", "post-done sec_type", sec_type, 1);
        check("R10", "post-done sect_type", sect_type, 2);
        check("R10", "post-done encrypted", encrypted, 0);
        check("R10", "post-done ratio_code", ratio_code, 2);

        // R10: after a length error, outputs also hold.
        pulse_start();
        feed(VECS[7]);
        feed(VECS[0]);
        check("R10", "post-error len_err", len_err, 1);
        check("R10", "post-error ratio_valid", ratio_valid, 0);
        check("R10", "post-error done count", done_hits, 0);

        // R1: start clears a finished result.
        pulse_start();
        feed(VECS[6]);
        pulse_start();
        check_cleared("start");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule